// File: doc/BRIEF.md
# I/O Register Bank with Per-Register Collision Policies

This block holds a 128-byte window of memory-mapped I/O registers shared by two sides. A CPU side writes and reads bytes through a 16-bit address, and it may write only in the first tick of each four-tick machine cycle. A peripheral side reads one register combinationally every tick, and it may write any register in any tick. When the CPU write and the peripheral's access hit the same register in the same tick, a per-register policy decides the result. The peripheral may see the old value, the new value, or the bitwise OR of the two. Under the fourth policy, the CPU write is held for one tick so that it overrides a peripheral write.

Two policy tables are built into the block as synthesized ROMs, and the `model_sel` input picks one of them. Each entry holds a 2-bit code: 0 keep-old, 1 show-new, 2 merge-OR, 3 CPU-first. The indices of the registers named in the tables are module parameters.

Top module: `mmio_conflict_bank`

## Requirements
- R1: A synchronous reset clears every register to 0x00 and discards any staged CPU write. After reset both read ports return 0x00.
- R2: The machine-cycle phase counts 0..3 and starts at phase 0 in the first tick after reset is released. A CPU write strobe is accepted only in a phase-0 tick. In other ticks it is ignored.
- R3: A CPU address lies in the window only when (address AND 0xFF80) equals 0xFF00, and its low 7 bits select the register. Writes outside the window change nothing, and `cpu_rdata` returns 0x00 for addresses outside the window.
- R4: Keep-old (code 0, and the default for every entry not listed): a peripheral read of the written register in the write tick returns the previous value. The new value is visible from the next tick.
- R5: Show-new (code 1): a peripheral read of the written register in the write tick returns the written byte.
- R6: Merge-OR (code 2): a peripheral read of the written register in the write tick returns old OR new. From the next tick the register holds the new byte.
- R7: CPU-first (code 3): the write commits one tick later than under keep-old, so the peripheral sees the old value in the write tick and in the tick after it. If the peripheral writes the register in either of those ticks, the final value is still the CPU's byte.
- R8: Under codes 0, 1 and 2, a peripheral write to the same register in the CPU write tick wins, and the register then holds the peripheral's byte.
- R9: With `model_sel`=0, index 0x0F uses CPU-first, indices 0x47, 0x48 and 0x49 use merge-OR, and indices 0x40, 0x41, 0x42, 0x43, 0x45, 0x4A and 0x4B use show-new. With `model_sel`=1, index 0x0F uses CPU-first and every other index uses keep-old.
- R10: `cpu_rdata` always returns the committed register value. A same-tick or staged CPU write does not affect it.
- R11: A peripheral write commits at the end of its tick in any phase and is then visible on both read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| model_sel | input | 1 | Policy table select |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Committed value at cpu_addr |
| per_addr | input | 7 | Peripheral register index |
| per_we | input | 1 | Peripheral write strobe |
| per_wdata | input | 8 | Peripheral write byte |
| per_rdata | output | 8 | Peripheral view of the indexed register |

## Verification
The bench makes CPU writes and peripheral reads or writes collide on the same register under every policy code and under both tables. A design with a wrong forwarding mux would show the old byte where the new byte or the OR belongs. A CPU-first write that is not staged would lose to a peripheral write made one tick later. The bench also issues writes off phase 0 and outside the window, which a design that skipped the qualification would let through. It resets while a CPU-first write is staged, which catches a staging register that survives reset and commits afterwards.

// File: rtl/mmio_bank_pkg.sv
`timescale 1ns/1ps
package mmio_bank_pkg;
   typedef enum logic [1:0] {
      POL_KEEP_OLD  = 2'd0,
      POL_SHOW_NEW  = 2'd1,
      POL_MERGE_OR  = 2'd2,
      POL_CPU_FIRST = 2'd3
   } pol_e;
endpackage

// File: rtl/mmio_tick_phase.sv
`timescale 1ns/1ps
module mmio_tick_phase #(
   parameter int TICKS = 4
) (
   input  logic clk,
   input  logic rst,
   output logic first_tick
);
   localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign first_tick = (cnt == '0);
endmodule

// File: rtl/mmio_policy_rom.sv
`timescale 1ns/1ps
module mmio_policy_rom
   import mmio_bank_pkg::*;
#(
   parameter int IDX_W = 7,
   parameter int IRQ_FLAG_IDX = 'h0F,
   parameter int LCD_CTRL_IDX = 'h40,
   parameter int LCD_STAT_IDX = 'h41,
   parameter int SCROLL_Y_IDX = 'h42,
   parameter int SCROLL_X_IDX = 'h43,
   parameter int LINE_CMP_IDX = 'h45,
   parameter int PAL_BG_IDX   = 'h47,
   parameter int PAL_OB0_IDX  = 'h48,
   parameter int PAL_OB1_IDX  = 'h49,
   parameter int WIN_Y_IDX    = 'h4A,
   parameter int WIN_X_IDX    = 'h4B
) (
   input  logic             model_sel,
   input  logic [IDX_W-1:0] idx,
   output pol_e             pol
);
   localparam int ENTRIES = 1 << IDX_W;

   pol_e tbl_a [ENTRIES];
   pol_e tbl_b [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      localparam bit IS_IRQ = (i == IRQ_FLAG_IDX);
      localparam bit IS_PAL = (i == PAL_BG_IDX) || (i == PAL_OB0_IDX) || (i == PAL_OB1_IDX);
      localparam bit IS_NEW = (i == LCD_CTRL_IDX) || (i == LCD_STAT_IDX) ||
                              (i == SCROLL_Y_IDX) || (i == SCROLL_X_IDX) ||
                              (i == LINE_CMP_IDX) || (i == WIN_Y_IDX) || (i == WIN_X_IDX);
      if (IS_IRQ) begin : g_irq
         assign tbl_a[i] = POL_CPU_FIRST;
         assign tbl_b[i] = POL_CPU_FIRST;
      end else if (IS_PAL) begin : g_pal
         assign tbl_a[i] = POL_MERGE_OR;
         assign tbl_b[i] = POL_KEEP_OLD;
      end else if (IS_NEW) begin : g_new
         assign tbl_a[i] = POL_SHOW_NEW;
         assign tbl_b[i] = POL_KEEP_OLD;
      end else begin : g_dflt
         assign tbl_a[i] = POL_KEEP_OLD;
         assign tbl_b[i] = POL_KEEP_OLD;
      end
   end

   assign pol = model_sel ? tbl_b[idx] : tbl_a[idx];
endmodule

// File: rtl/mmio_cpu_stage.sv
`timescale 1ns/1ps
module mmio_cpu_stage #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic [DATA_W-1:0] load_data,
   output logic              vld,
   output logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         vld  <= 1'b0;
         idx  <= '0;
         data <= '0;
      end else begin
         vld <= load;
         if (load) begin
            idx  <= load_idx;
            data <= load_data;
         end
      end
   end

   assert_one_tick_R7: assert property (@(posedge clk) disable iff (rst) vld |=> !vld);
   assert_reset_drop_R1: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !vld);
endmodule

// File: rtl/mmio_reg_array.sv
`timescale 1ns/1ps
module mmio_reg_array #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dir_we,
   input  logic [IDX_W-1:0]  dir_idx,
   input  logic [DATA_W-1:0] dir_data,
   input  logic              per_we,
   input  logic [IDX_W-1:0]  per_idx,
   input  logic [DATA_W-1:0] per_data,
   input  logic              stg_we,
   input  logic [IDX_W-1:0]  stg_idx,
   input  logic [DATA_W-1:0] stg_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [DATA_W-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
         if (rst)                                   mem[e] <= '0;
         else if (stg_we && stg_idx == IDX_W'(e))   mem[e] <= stg_data;
         else if (per_we && per_idx == IDX_W'(e))   mem[e] <= per_data;
         else if (dir_we && dir_idx == IDX_W'(e))   mem[e] <= dir_data;
      end
   end

   assign rd_a_data = mem[rd_a_idx];
   assign rd_b_data = mem[rd_b_idx];

   assert_no_dual_cpu_R2: assert property (@(posedge clk) disable iff (rst) !(dir_we && stg_we));
   assert_stage_final_R7: assert property (@(posedge clk) disable iff (rst)
      stg_we |=> (mem[$past(stg_idx)] == $past(stg_data)));
endmodule

// File: rtl/mmio_conflict_bank.sv
`timescale 1ns/1ps
module mmio_conflict_bank
   import mmio_bank_pkg::*;
#(
   parameter int          TICKS_PER_MCYCLE = 4,
   parameter int          CPU_AW    = 16,
   parameter int          IDX_W     = 7,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] WIN_BASE  = 16'hFF00,
   parameter int IRQ_FLAG_IDX = 'h0F,
   parameter int LCD_CTRL_IDX = 'h40,
   parameter int LCD_STAT_IDX = 'h41,
   parameter int SCROLL_Y_IDX = 'h42,
   parameter int SCROLL_X_IDX = 'h43,
   parameter int LINE_CMP_IDX = 'h45,
   parameter int PAL_BG_IDX   = 'h47,
   parameter int PAL_OB0_IDX  = 'h48,
   parameter int PAL_OB1_IDX  = 'h49,
   parameter int WIN_Y_IDX    = 'h4A,
   parameter int WIN_X_IDX    = 'h4B
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              model_sel,
   input  logic              cpu_we,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [IDX_W-1:0]  per_addr,
   input  logic              per_we,
   input  logic [DATA_W-1:0] per_wdata,
   output logic [DATA_W-1:0] per_rdata
);
   localparam logic [CPU_AW-1:0] WIN_MASK = {CPU_AW{1'b1}} << IDX_W;
   localparam logic [CPU_AW-1:0] WIN_TAG  = CPU_AW'(WIN_BASE);

   if (TICKS_PER_MCYCLE < 2) begin : g_bad_ticks
      $error("machine cycle must span at least two ticks for staged commits");
   end
   if (IDX_W >= CPU_AW) begin : g_bad_idx
      $error("register index must be narrower than the CPU address");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("data width must be positive");
   end

   logic              first_tick;
   logic              in_win;
   logic [IDX_W-1:0]  cpu_idx;
   logic              acc;
   pol_e              pol;
   logic              dir_we;
   logic              stg_load;
   logic              stg_vld;
   logic [IDX_W-1:0]  stg_idx;
   logic [DATA_W-1:0] stg_data;
   logic [DATA_W-1:0] rd_cpu;
   logic [DATA_W-1:0] rd_per;
   logic              hit;

   mmio_tick_phase #(.TICKS(TICKS_PER_MCYCLE)) u_phase (
      .clk(clk), .rst(rst), .first_tick(first_tick)
   );

   assign in_win  = (cpu_addr & WIN_MASK) == WIN_TAG;
   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign acc     = cpu_we && first_tick && in_win;

   mmio_policy_rom #(
      .IDX_W(IDX_W), .IRQ_FLAG_IDX(IRQ_FLAG_IDX),
      .LCD_CTRL_IDX(LCD_CTRL_IDX), .LCD_STAT_IDX(LCD_STAT_IDX),
      .SCROLL_Y_IDX(SCROLL_Y_IDX), .SCROLL_X_IDX(SCROLL_X_IDX),
      .LINE_CMP_IDX(LINE_CMP_IDX), .PAL_BG_IDX(PAL_BG_IDX),
      .PAL_OB0_IDX(PAL_OB0_IDX), .PAL_OB1_IDX(PAL_OB1_IDX),
      .WIN_Y_IDX(WIN_Y_IDX), .WIN_X_IDX(WIN_X_IDX)
   ) u_rom (
      .model_sel(model_sel), .idx(cpu_idx), .pol(pol)
   );

   assign stg_load = acc && (pol == POL_CPU_FIRST);
   assign dir_we   = acc && (pol != POL_CPU_FIRST);

   mmio_cpu_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_stage (
      .clk(clk), .rst(rst),
      .load(stg_load), .load_idx(cpu_idx), .load_data(cpu_wdata),
      .vld(stg_vld), .idx(stg_idx), .data(stg_data)
   );

   mmio_reg_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst),
      .dir_we(dir_we), .dir_idx(cpu_idx), .dir_data(cpu_wdata),
      .per_we(per_we), .per_idx(per_addr), .per_data(per_wdata),
      .stg_we(stg_vld), .stg_idx(stg_idx), .stg_data(stg_data),
      .rd_a_idx(cpu_idx), .rd_a_data(rd_cpu),
      .rd_b_idx(per_addr), .rd_b_data(rd_per)
   );

   assign hit = acc && (per_addr == cpu_idx);

   always_comb begin
      per_rdata = rd_per;
      if (hit) begin
         case (pol)
            POL_SHOW_NEW: per_rdata = cpu_wdata;
            POL_MERGE_OR: per_rdata = rd_per | cpu_wdata;
            default:      per_rdata = rd_per;
         endcase
      end
   end

   assign cpu_rdata = in_win ? rd_cpu : '0;

   assert_stage_off_phase_R2: assert property (@(posedge clk) disable iff (rst)
      stg_vld |-> !first_tick);
   assert_keep_old_view_R4: assert property (@(posedge clk) disable iff (rst)
      (hit && pol == POL_KEEP_OLD) |-> (per_rdata == cpu_rdata));
   assert_merge_cover_R6: assert property (@(posedge clk) disable iff (rst)
      (hit && pol == POL_MERGE_OR) |-> ((per_rdata & cpu_wdata) == cpu_wdata));
   assert_cpu_first_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (hit && pol == POL_CPU_FIRST) |-> (per_rdata == cpu_rdata));
endmodule

// File: tb/tb_mmio_conflict_bank.sv
`timescale 1ns/1ps
module tb_mmio_conflict_bank;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        model_sel = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = 16'hFF00;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  cpu_rdata;
   logic [6:0]  per_addr = 7'h00;
   logic        per_we = 1'b0;
   logic [7:0]  per_wdata = 8'h00;
   logic [7:0]  per_rdata;

   always #2.5 clk = ~clk;

   mmio_conflict_bank dut (
      .clk(clk), .rst(rst), .model_sel(model_sel),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .per_addr(per_addr), .per_we(per_we), .per_wdata(per_wdata), .per_rdata(per_rdata)
   );

   typedef struct {
      string      req;
      bit         on_cpu;
      logic [7:0] exp;
   } item_t;

   item_t sbq [$];
   int    total = 0;
   int    bad   = 0;
   int    nph   = 0;
   bit    done  = 1'b0;

   // monitor: samples 1 ns after the falling edge the driver used
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = it.on_cpu ? cpu_rdata : per_rdata;
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s %s port: actual=%02h expected=%02h",
                        it.req, it.on_cpu ? "cpu" : "per", act, it.exp);
            end
         end
      end
   end

   task automatic expect_per(input string req, input logic [7:0] v);
      item_t it;
      it.req = req; it.on_cpu = 1'b0; it.exp = v;
      sbq.push_back(it);
   endtask

   task automatic expect_cpu(input string req, input logic [7:0] v);
      item_t it;
      it.req = req; it.on_cpu = 1'b1; it.exp = v;
      sbq.push_back(it);
   endtask

   task automatic tick(input bit cw, input logic [15:0] ca, input logic [7:0] cd,
                       input logic [6:0] pa, input bit pw, input logic [7:0] pd);
      @(negedge clk);
      cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
      per_addr = pa; per_we = pw; per_wdata = pd;
      nph = (nph + 1) % 4;
   endtask

   task automatic idle(input logic [15:0] ca, input logic [6:0] pa);
      tick(1'b0, ca, 8'h00, pa, 1'b0, 8'h00);
   endtask

   // next driven tick becomes phase 0
   task automatic align();
      while (nph != 0) idle(cpu_addr, per_addr);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cpu_we = 1'b0; per_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      nph = 1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      idle(16'hFF47, 7'h0F); expect_cpu("R1", 8'h00); expect_per("R1", 8'h00);
      idle(16'hFF0F, 7'h7F); expect_cpu("R1", 8'h00); expect_per("R1", 8'h00);

      // R4 keep-old on unlisted index 0x10, R10 committed cpu view
      align();
      tick(1, 16'hFF10, 8'hA5, 7'h10, 0, 8'h00); expect_per("R4", 8'h00); expect_cpu("R10", 8'h00);
      idle(16'hFF10, 7'h10); expect_per("R4", 8'hA5); expect_cpu("R10", 8'hA5);

      // R5 show-new on 0x40 (model 0)
      align(); tick(1, 16'hFF40, 8'h11, 7'h00, 0, 8'h00);
      align(); tick(1, 16'hFF40, 8'h22, 7'h40, 0, 8'h00);
      expect_per("R5", 8'h22); expect_cpu("R10", 8'h11);
      idle(16'hFF40, 7'h40); expect_per("R5", 8'h22);

      // R6 merge-OR on 0x47 (model 0)
      align(); tick(1, 16'hFF47, 8'h0F, 7'h00, 0, 8'h00);
      align(); tick(1, 16'hFF47, 8'hF0, 7'h47, 0, 8'h00);
      expect_per("R6", 8'hFF); expect_cpu("R10", 8'h0F);
      idle(16'hFF47, 7'h47); expect_per("R6", 8'hF0); expect_cpu("R6", 8'hF0);

      // R7 CPU-first on 0x0F, peripheral writes in the following tick
      align(); tick(1, 16'hFF0F, 8'h81, 7'h0F, 0, 8'h00); expect_per("R7", 8'h00);
      tick(0, 16'hFF0F, 8'h00, 7'h0F, 1, 8'h3C); expect_per("R7", 8'h00);
      idle(16'hFF0F, 7'h0F); expect_per("R7", 8'h81); expect_cpu("R7", 8'h81);

      // R7 CPU-first with peripheral write in the same tick
      align(); tick(1, 16'hFF0F, 8'h42, 7'h0F, 1, 8'h3C); expect_per("R7", 8'h81);
      idle(16'hFF0F, 7'h0F); expect_per("R7", 8'h3C);
      idle(16'hFF0F, 7'h0F); expect_per("R7", 8'h42); expect_cpu("R7", 8'h42);

      // R8 peripheral wins under keep-old and show-new
      align(); tick(1, 16'hFF10, 8'h77, 7'h10, 1, 8'h44); expect_per("R8", 8'hA5);
      idle(16'hFF10, 7'h10); expect_per("R8", 8'h44); expect_cpu("R8", 8'h44);
      align(); tick(1, 16'hFF40, 8'h99, 7'h40, 1, 8'h55); expect_per("R8", 8'h99);
      idle(16'hFF40, 7'h40); expect_per("R8", 8'h55);

      // R2 writes off phase 0 are ignored
      align(); idle(16'hFF10, 7'h10);
      tick(1, 16'hFF10, 8'hEE, 7'h10, 0, 8'h00); expect_per("R2", 8'h44);
      tick(1, 16'hFF10, 8'hEE, 7'h10, 0, 8'h00);
      tick(1, 16'hFF10, 8'hEE, 7'h10, 0, 8'h00);
      idle(16'hFF10, 7'h10); expect_per("R2", 8'h44); expect_cpu("R2", 8'h44);

      // R3 out-of-window write and read
      align(); tick(1, 16'hFE10, 8'hBB, 7'h10, 0, 8'h00);
      expect_per("R3", 8'h44); expect_cpu("R3", 8'h00);
      idle(16'hFF10, 7'h10); expect_cpu("R3", 8'h44); expect_per("R3", 8'h44);
      align(); tick(1, 16'h7F10, 8'hBB, 7'h10, 0, 8'h00);
      idle(16'hFF10, 7'h10); expect_cpu("R3", 8'h44);

      // R11 peripheral write in a non-zero phase
      align(); idle(16'hFF20, 7'h20);
      tick(0, 16'hFF20, 8'h00, 7'h20, 1, 8'h6D);
      idle(16'hFF20, 7'h20); expect_cpu("R11", 8'h6D); expect_per("R11", 8'h6D);

      // R9 second table
      model_sel = 1'b1;
      align(); tick(1, 16'hFF47, 8'h0F, 7'h47, 0, 8'h00); expect_per("R9", 8'hF0);
      idle(16'hFF47, 7'h47); expect_per("R9", 8'h0F);
      align(); tick(1, 16'hFF40, 8'h5A, 7'h40, 0, 8'h00); expect_per("R9", 8'h55);
      idle(16'hFF40, 7'h40); expect_per("R9", 8'h5A);
      align(); tick(1, 16'hFF0F, 8'h24, 7'h0F, 0, 8'h00);
      tick(0, 16'hFF0F, 8'h00, 7'h0F, 1, 8'h18); expect_per("R9", 8'h42);
      idle(16'hFF0F, 7'h0F); expect_per("R9", 8'h24);

      // R1 reset while a CPU-first write is staged
      model_sel = 1'b0;
      align(); tick(1, 16'hFF0F, 8'hC3, 7'h0F, 0, 8'h00);
      @(negedge clk); rst = 1'b1; cpu_we = 1'b0;
      @(negedge clk); rst = 1'b0; nph = 1;
      expect_per("R1", 8'h00); expect_cpu("R1", 8'h00);
      idle(16'hFF0F, 7'h0F); expect_per("R1", 8'h00); expect_cpu("R1", 8'h00);
      idle(16'hFF47, 7'h10); expect_cpu("R1", 8'h00); expect_per("R1", 8'h00);

      idle(16'hFF00, 7'h00);
      idle(16'hFF00, 7'h00);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule